// File: doc/BRIEF.md
# Infrared pulse-width symbol receiver

This block samples a demodulated infrared line and turns it into a stream of timed symbols. The line rests high. A stream begins at the first falling edge. Each symbol is a low phase followed by a high phase. Both widths are counted in a coarse time unit and packed into a single 32-bit word. The word is queued in a 32-entry receive queue when the next falling edge closes the high phase.

A stream ends when the line has stayed in one symbol for the configured maximum width, measured as the sum of the two phases. That last symbol is queued as well. It raises a timeout condition instead of a normal receive. The block then waits for a new falling edge.

Software sees a small word-addressed register set. Through it, software enables and arms the receiver, sets the time base and limits, reads the queue depth, and pops symbols. It also handles three interrupt sources: receive, timeout and overflow. Each source has a mask bit, a status bit and a clear bit.

Top module: `irrx_core`

## Requirements
- R1: After reset, CONFIG (0x04) reads 0x3E80_0080, MASK (0x28) reads 0x0000_0700, STATUS (0x2C) reads 0, COUNT (0x20) reads 0, and `irq` is low.
- R2: A queued symbol word holds the low-phase width in bits 15:0 and the high-phase width in bits 31:16. Widths are in units of (CONFIG[6:0]+1)*10 clock cycles. A symbol is queued when the falling edge that ends its high phase is seen.
- R3: When the low width plus the high width reaches CONFIG[31:16], the symbol is queued at once. STATUS bit 25 is set, and the receiver returns to idle until the next falling edge.
- R4: A read of COUNT (0x20) returns the number of queued symbols. Each read of DATA (0x24) returns the oldest symbol and removes it. A DATA read on an empty queue returns 0 and changes nothing.
- R5: STATUS bit 24 (receive) is set when a normally ended symbol is queued and the count after the push exceeds CONFIG[13:8]. A timeout symbol does not set it.
- R6: MASK bits 10:8 disable receive, timeout and overflow when 1. STATUS bits 26:24 hold the raw flags and bits 10:8 hold the flags with the mask applied. `irq` is the OR of STATUS bits 10:8.
- R7: Writing 1 to CLEAR (0x30) bit 16, 17 or 18 clears receive, timeout or overflow respectively. An overflow clear has no effect while the queue is not empty.
- R8: The queue holds 32 symbols. A symbol arriving while the queue is full is dropped, the stored symbols are kept, and STATUS bit 26 is set.
- R9: Symbols are captured only while ENABLE (0x00) bit 0 is 1 and a write of any value to START (0x34) has been made since the last time bit 0 was written 0. Writing bit 0 as 0 disarms the receiver and returns it to idle.
- R10: BUSY (0x1C) reads 1 while a stream is in progress and 0 when the receiver is idle.
- R11: Changing CONFIG[6:0] scales the width unit, so a value of 1 gives a unit of 20 clock cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ir_in | input | 1 | Demodulated infrared line; rests high |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe; pops the queue when it addresses DATA |
| addr | input | 6 | Register byte address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, valid in the same cycle |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume that the software side writes the queue-depth bound correctly. They also assume that the overflow flag is only raised from a full queue and that a stream only runs while the receiver is enabled. Bus strobes are taken to be one cycle wide. The stimulus drives every line change and every bus access on the falling clock edge, so no input changes at the sampling edge. Each phase length is chosen as a whole number of units plus half a unit, so the expected width does not depend on the two-flop synchroniser delay. Every queue is drained before the next scenario rewrites the configuration.

// File: rtl/irrx_core.sv
module irrx_core #(
  parameter int DEPTH = 32,
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ir_in,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [AW-1:0] addr,
  input  logic [31:0]   wdata,
  output logic [31:0]   rdata,
  output logic          irq
);
  localparam int CW = $clog2(DEPTH + 1);
  localparam int PW = $clog2(DEPTH);
  localparam logic [31:0] CFG_RST = {16'd16000, 2'b00, 6'd0, 1'b1, 7'd0};
  localparam logic [AW-1:0] A_EN = AW'('h00), A_CFG = AW'('h04), A_BUSY = AW'('h1C),
    A_CNT = AW'('h20), A_DAT = AW'('h24), A_MASK = AW'('h28), A_STS = AW'('h2C),
    A_CLR = AW'('h30), A_GO = AW'('h34);

  typedef enum logic [1:0] {S_IDLE, S_LOW, S_HIGH} rx_t;

  logic        on, armed;
  logic [31:0] cfg;
  logic [2:0]  mask, sts;
  rx_t         state;
  logic [2:0]  ir_q;
  logic [15:0] lo_w, hi_w;
  logic [6:0]  us_c;
  logic [3:0]  dec_c;
  logic [31:0] mem [DEPTH];
  logic [PW-1:0] wp, rp;
  logic [CW-1:0] cnt, cnt_nx;

  wire live = on & armed;
  wire fall = ir_q[2] & ~ir_q[1];
  wire rise = ~ir_q[2] & ir_q[1];
  wire [15:0] maxw = cfg[31:16];
  wire [5:0]  level = cfg[13:8];
  wire [6:0]  freq = cfg[6:0];
  wire hit  = ({1'b0, lo_w} + {1'b0, hi_w}) >= {1'b0, maxw};
  wire tick = (us_c == freq) && (dec_c == 4'd9);
  wire busy = (state != S_IDLE);

  logic push, to_evt;
  always_comb begin
    push = 1'b0;
    to_evt = 1'b0;
    case (state)
      S_LOW:  if (hit) begin push = 1'b1; to_evt = 1'b1; end
      S_HIGH: if (fall) push = 1'b1;
              else if (hit) begin push = 1'b1; to_evt = 1'b1; end
      default: ;
    endcase
  end

  wire full = (cnt == CW'(DEPTH));
  wire wr   = push & ~full;
  wire ovf  = push & full;
  wire pop  = rd_en && (addr == A_DAT) && (cnt != '0);
  wire clr  = wr_en && (addr == A_CLR);
  assign cnt_nx = cnt + CW'(wr) - CW'(pop);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) ir_q <= 3'b111;
    else        ir_q <= {ir_q[1:0], ir_in};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      on <= 1'b0; armed <= 1'b0; cfg <= CFG_RST; mask <= 3'b111;
    end else if (wr_en) begin
      case (addr)
        A_EN:   begin on <= wdata[0]; if (!wdata[0]) armed <= 1'b0; end
        A_CFG:  cfg <= wdata;
        A_MASK: mask <= wdata[10:8];
        A_GO:   armed <= 1'b1;
        default: ;
      endcase
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      us_c <= '0; dec_c <= '0;
    end else if (!live || state == S_IDLE || rise || fall) begin
      us_c <= '0; dec_c <= '0;
    end else if (us_c == freq) begin
      us_c <= '0;
      dec_c <= (dec_c == 4'd9) ? 4'd0 : dec_c + 4'd1;
    end else us_c <= us_c + 7'd1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      state <= S_IDLE; lo_w <= '0; hi_w <= '0;
    end else if (!live) begin
      state <= S_IDLE; lo_w <= '0; hi_w <= '0;
    end else begin
      case (state)
        S_IDLE: if (fall) begin state <= S_LOW; lo_w <= '0; hi_w <= '0; end
        S_LOW:
          if (hit) state <= S_IDLE;
          else if (rise) state <= S_HIGH;
          else if (tick && lo_w != 16'hFFFF) lo_w <= lo_w + 16'd1;
        S_HIGH:
          if (fall) begin state <= S_LOW; lo_w <= '0; hi_w <= '0; end
          else if (hit) state <= S_IDLE;
          else if (tick && hi_w != 16'hFFFF) hi_w <= hi_w + 16'd1;
        default: state <= S_IDLE;
      endcase
    end

  always_ff @(posedge clk)
    if (wr) mem[wp] <= {hi_w, lo_w};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      wp <= '0; rp <= '0; cnt <= '0;
    end else begin
      if (wr)  wp <= (wp == PW'(DEPTH - 1)) ? '0 : wp + 1'b1;
      if (pop) rp <= (rp == PW'(DEPTH - 1)) ? '0 : rp + 1'b1;
      cnt <= cnt_nx;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sts <= '0;
    else begin
      if (wr && !to_evt && int'(cnt_nx) > int'(level)) sts[0] <= 1'b1;
      else if (clr && wdata[16]) sts[0] <= 1'b0;
      if (to_evt) sts[1] <= 1'b1;
      else if (clr && wdata[17]) sts[1] <= 1'b0;
      if (ovf) sts[2] <= 1'b1;
      else if (clr && wdata[18] && cnt == '0) sts[2] <= 1'b0;
    end

  always_comb
    case (addr)
      A_EN:    rdata = {31'b0, on};
      A_CFG:   rdata = cfg;
      A_BUSY:  rdata = {31'b0, busy};
      A_CNT:   rdata = {{(32-CW){1'b0}}, cnt};
      A_DAT:   rdata = (cnt != '0) ? mem[rp] : 32'b0;
      A_MASK:  rdata = {21'b0, mask, 8'b0};
      A_STS:   rdata = {5'b0, sts, 13'b0, sts & ~mask, 8'b0};
      default: rdata = 32'b0;
    endcase

  assign irq = |(sts & ~mask);
endmodule

// File: rtl/irrx_core_chk.sv
module irrx_core_chk #(
  parameter int DEPTH = 32,
  parameter int CW = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          on,
  input logic          busy,
  input logic          pop_req,
  input logic [CW-1:0] cnt,
  input logic [2:0]    sts
);
  a_r8_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(DEPTH));
  a_r8_ovf_from_full: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sts[2]) |-> $past(cnt) == CW'(DEPTH));
  a_r7_ovf_held: assert property (@(posedge clk) disable iff (!rst_n)
    (sts[2] && cnt != '0) |=> sts[2]);
  a_r9_off_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !on |=> !busy);
  a_r3_timeout_idle: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sts[1]) |-> !busy);
  a_r4_empty_pop: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_req && cnt == '0) |=> cnt <= CW'(1));
endmodule

bind irrx_core irrx_core_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .on(on), .busy(busy),
  .pop_req(rd_en && addr == A_DAT), .cnt(cnt), .sts(sts)
);

// File: tb/irrx_core_test.sv
module irrx_core_test;
  localparam int CLK_P = 10;
  localparam logic [5:0] A_EN = 6'h00, A_CFG = 6'h04, A_BUSY = 6'h1C, A_CNT = 6'h20,
    A_DAT = 6'h24, A_MASK = 6'h28, A_STS = 6'h2C, A_CLR = 6'h30, A_GO = 6'h34;

  logic clk = 1'b0, rst_n = 1'b0, ir_in = 1'b1, wr_en = 1'b0, rd_en = 1'b0;
  logic [5:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;
  int checks = 0, errors = 0;

  irrx_core uut (.clk(clk), .rst_n(rst_n), .ir_in(ir_in), .wr_en(wr_en), .rd_en(rd_en),
                 .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq));

  always #(CLK_P/2) clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    rd_en = 1'b1; addr = a;
    #1 d = rdata;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic ph(input logic lvl, input int n);
    ir_in = lvl;
    repeat (n) @(negedge clk);
  endtask

  task automatic drain();
    logic [31:0] n, d;
    rd(A_CNT, n);
    for (int i = 0; i < int'(n); i++) rd(A_DAT, d);
  endtask

  task automatic setup(input logic [15:0] maxw, input logic [5:0] lvl, input logic [6:0] fq);
    wr(A_EN, 0);
    wr(A_CFG, {maxw, 2'b00, lvl, 1'b1, fq});
    wr(A_MASK, 0);
    wr(A_CLR, 32'h0007_0000);
    wr(A_EN, 1);
    wr(A_GO, 32'h1234);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(A_CFG, d);  chk("R1 config", d, 32'h3E80_0080);
    rd(A_MASK, d); chk("R1 mask", d, 32'h0000_0700);
    rd(A_STS, d);  chk("R1 status", d, 0);
    rd(A_CNT, d);  chk("R1 count", d, 0);
    chk("R1 irq", {31'b0, irq}, 0);
  endtask

  task automatic t_basic();
    logic [31:0] d;
    setup(20, 0, 0);
    ph(0, 35); ph(1, 55); ph(0, 25);
    ir_in = 1'b1;
    rd(A_CNT, d);  chk("R2 count after first symbol", d, 1);
    rd(A_BUSY, d); chk("R10 busy in stream", d, 1);
    rd(A_STS, d);  chk("R5 receive flag", d, 32'h0100_0100);
    chk("R6 irq on receive", {31'b0, irq}, 1);
    repeat (300) @(negedge clk);
    rd(A_CNT, d);  chk("R3 count after timeout", d, 2);
    rd(A_STS, d);  chk("R3 timeout flag", d, 32'h0300_0300);
    rd(A_BUSY, d); chk("R10 idle after timeout", d, 0);
    rd(A_DAT, d);  chk("R2 first word", d, 32'h0005_0003);
    rd(A_CNT, d);  chk("R4 count after pop", d, 1);
    rd(A_DAT, d);  chk("R3 timeout word", d, 32'h0012_0002);
    rd(A_DAT, d);  chk("R4 empty read", d, 0);
    rd(A_CNT, d);  chk("R4 empty count", d, 0);
    wr(A_CLR, 32'h0003_0000);
    rd(A_STS, d);  chk("R7 cleared", d, 0);
    chk("R7 irq low", {31'b0, irq}, 0);
  endtask

  task automatic t_mask();
    logic [31:0] d;
    setup(20, 0, 0);
    wr(A_MASK, 32'h0000_0700);
    ph(0, 15); ph(1, 15); ph(0, 15);
    ir_in = 1'b1;
    rd(A_STS, d);  chk("R6 raw only when masked", d, 32'h0100_0000);
    chk("R6 irq masked", {31'b0, irq}, 0);
    wr(A_MASK, 32'h0000_0600);
    chk("R6 irq unmasked", {31'b0, irq}, 1);
    repeat (300) @(negedge clk);
    drain();
  endtask

  task automatic t_arm();
    logic [31:0] d;
    setup(20, 0, 0);
    wr(A_EN, 0); wr(A_EN, 1);
    ph(0, 35); ph(1, 25); ph(0, 25); ph(1, 40);
    rd(A_CNT, d);  chk("R9 no capture unarmed", d, 0);
    rd(A_BUSY, d); chk("R9 idle unarmed", d, 0);
    wr(A_GO, 0);
    ph(0, 35); ph(1, 25); ph(0, 25);
    ir_in = 1'b1;
    repeat (300) @(negedge clk);
    rd(A_CNT, d);  chk("R9 capture after start", d, 2);
    rd(A_DAT, d);  chk("R9 word after start", d, 32'h0002_0003);
    drain();
  endtask

  task automatic t_level();
    logic [31:0] d;
    setup(20, 2, 0);
    ph(0, 15); ph(1, 15); ph(0, 15); ph(1, 15); ph(0, 15);
    rd(A_CNT, d);  chk("R5 count at level", d, 2);
    rd(A_STS, d);  chk("R5 no flag at level", d, 0);
    ph(1, 15); ph(0, 15);
    ir_in = 1'b1;
    rd(A_STS, d);  chk("R5 flag above level", d, 32'h0100_0100);
    repeat (300) @(negedge clk);
    drain();
  endtask

  task automatic t_overflow();
    logic [31:0] d;
    setup(20, 0, 0);
    for (int i = 0; i < 33; i++) begin ph(0, 15); ph(1, 15); end
    repeat (300) @(negedge clk);
    rd(A_CNT, d);  chk("R8 count full", d, 32);
    rd(A_STS, d);  chk("R8 overflow flag", d & 32'h0400_0000, 32'h0400_0000);
    rd(A_DAT, d);  chk("R8 oldest kept", d, 32'h0001_0001);
    wr(A_CLR, 32'h0004_0000);
    rd(A_STS, d);  chk("R7 overflow clear ignored", d & 32'h0400_0000, 32'h0400_0000);
    drain();
    wr(A_CLR, 32'h0004_0000);
    rd(A_STS, d);  chk("R7 overflow cleared empty", d & 32'h0400_0000, 0);
  endtask

  task automatic t_freq();
    logic [31:0] d;
    setup(40, 0, 1);
    ph(0, 70); ph(1, 110); ph(0, 30);
    ir_in = 1'b1;
    repeat (1000) @(negedge clk);
    rd(A_DAT, d);  chk("R11 scaled word", d, 32'h0005_0003);
    rd(A_DAT, d);  chk("R11 scaled timeout word", d, 32'h0027_0001);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_mask();
    t_arm();
    t_level();
    t_overflow();
    t_freq();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule